// File: doc/BRIEF.md
# Closed-Loop Synthesizer Frequency Tracker

This block measures the frequency of an unknown digital square wave. It does not count edges over a gate time. It steers a numerically controlled oscillator until that oscillator runs at the input frequency. A phase accumulator adds a tuning word to itself on every clock, and its top bit forms a synthesized square wave. An edge-order detector watches the input and the synthesized wave and asks for the tuning word to go up or down. A rate-limited up/down counter applies those requests to the tuning word, and the tuning word in turn drives the accumulator.

At equality the loop keeps hunting. The tuning word swings by a step or so around the true value and never stops there. The block watches these turns of direction. Once they have stayed tight for a number of turns in a row, it raises a settled flag. It then reports the midpoint of the last swing, with one fractional bit, as the estimate. The input frequency is estimate / 2 · fclk / 2^ACC_W.

Top module: `freq_track_meter`

## Requirements
- R1: A synchronous, active-high `rst` clears the accumulator, the tuning word, the pending request and the settle state. On the first clock edge with `rst` high, `fsw_o`, `dds_sq_o`, `settled_o` and `estimate_o` all become zero.
- R2: The accumulator is ACC_W bits wide. On every clock it adds `fsw_o` modulo 2^ACC_W, and `dds_sq_o` is its most significant bit. The synthesized wave therefore runs at fsw·fclk/2^ACC_W, and it holds still while `fsw_o` is zero. In lock, the rising edges of `dds_sq_o` match those of `meas_in` within two over any window.
- R3: While `meas_in` stays constant and `fsw_o` is zero, no step is ever requested, so `fsw_o` stays at 0 and `settled_o` stays low.
- R4: `fsw_o` saturates at 2^(ACC_W-2), which is 256 by default and equals a quarter of the clock rate. An input faster than that leaves `fsw_o` at that limit, and `settled_o` stays low.
- R5: An input rising edge that follows an input rising edge with no synthesized rising edge between them requests one step up. The mirror case requests one step down. Coincident edges request nothing. As a result `fsw_o` climbs while the input is faster and falls while it is slower.
- R6: `fsw_o` changes only on a step tick, which comes once every STEP_DIV clocks. It changes by exactly one. At most one request is held, and each tick consumes it.
- R7: A reversal is an applied step whose direction is opposite to the previous applied step. `settled_o` rises once SETTLE_K reversals in a row have each come after no more than SPAN_MAX steps since the reversal before. `estimate_o` is the sum of the last two reversal-point tuning words, so its LSB weighs half a tuning step.
- R8: A run of more than SPAN_MAX steps in one direction clears the reversal count, so `settled_o` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_in | input | 1 | Unknown square wave, asynchronous |
| fsw_o | output | ACC_W | Current tuning word |
| dds_sq_o | output | 1 | Synthesized square wave (accumulator MSB) |
| settled_o | output | 1 | Loop has settled, estimate valid |
| estimate_o | output | ACC_W+1 | Midpoint of last dither span, one fractional bit |

## Verification
The loop is driven with input periods of 24, 40, 6 and 10 clocks. All four give targets that fall between two tuning words. This shows that the estimate lands on the half-step midpoint and not merely on one of the two hunting values, and the periods span the low, middle and upper part of the range. A constant input tells idle stability apart from lock. A period of two clocks lies beyond the quarter-rate limit and separates saturation from settling. A sudden period change after lock checks that the settled flag falls and that the tuning word moves in the new direction.

// File: rtl/ftm_pkg.sv
package ftm_pkg;
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_MEAS = 2'd1,
      SRC_DDS  = 2'd2
   } edge_src_e;

   typedef enum logic [1:0] {
      DIR_NONE = 2'd0,
      DIR_UP   = 2'd1,
      DIR_DN   = 2'd2
   } step_dir_e;
endpackage

// File: rtl/ftm_sync.sv
module ftm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   if (STAGES < 1) begin : g_bad_stages
      $error("ftm_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (rst) chain <= '0;
         else     chain <= d;
      end
   end else begin : g_chain
      always_ff @(posedge clk) begin
         if (rst) chain <= '0;
         else     chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ftm_phase_acc.sv
module ftm_phase_acc #(
   parameter int ACC_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ACC_W-1:0] fsw_i,
   output logic             sq_o
);
   logic [ACC_W-1:0] acc;

   always_ff @(posedge clk) begin
      if (rst) acc <= '0;
      else     acc <= acc + fsw_i;
   end

   assign sq_o = acc[ACC_W-1];

   // R2
   acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(fsw_i) == '0) |-> $stable(acc));
endmodule

// File: rtl/ftm_edge_order_det.sv
module ftm_edge_order_det
   import ftm_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic meas_i,
   input  logic dds_i,
   input  logic take_i,
   output logic up_o,
   output logic dn_o
);
   logic meas_s, dds_s, meas_p, dds_p;
   logic meas_rise, dds_rise, up_evt, dn_evt;
   edge_src_e last_q;

   ftm_sync #(.STAGES(SYNC_STAGES)) u_sync_meas (
      .clk(clk), .rst(rst), .d(meas_i), .q(meas_s));
   ftm_sync #(.STAGES(SYNC_STAGES)) u_sync_dds (
      .clk(clk), .rst(rst), .d(dds_i), .q(dds_s));

   assign meas_rise = meas_s & ~meas_p;
   assign dds_rise  = dds_s & ~dds_p;
   assign up_evt    = meas_rise & ~dds_rise & (last_q == SRC_MEAS);
   assign dn_evt    = dds_rise & ~meas_rise & (last_q == SRC_DDS);

   always_ff @(posedge clk) begin
      if (rst) begin
         meas_p <= 1'b0;
         dds_p  <= 1'b0;
         last_q <= SRC_NONE;
         up_o   <= 1'b0;
         dn_o   <= 1'b0;
      end else begin
         meas_p <= meas_s;
         dds_p  <= dds_s;
         if (meas_rise && !dds_rise)      last_q <= SRC_MEAS;
         else if (dds_rise && !meas_rise) last_q <= SRC_DDS;
         if (up_evt) begin
            up_o <= 1'b1;
            dn_o <= 1'b0;
         end else if (dn_evt) begin
            up_o <= 1'b0;
            dn_o <= 1'b1;
         end else if (take_i) begin
            up_o <= 1'b0;
            dn_o <= 1'b0;
         end
      end
   end

   // R5
   up_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(up_o) |-> $past(meas_rise));
   // R5
   dn_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(dn_o) |-> $past(dds_rise));
   // R6
   one_request_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({up_o, dn_o}));
endmodule

// File: rtl/ftm_tune_counter.sv
module ftm_tune_counter
   import ftm_pkg::*;
#(
   parameter int ACC_W    = 10,
   parameter int STEP_DIV = 4,
   parameter int SPAN_MAX = 4,
   parameter int SETTLE_K = 4
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           up_i,
   input  logic           dn_i,
   output logic           tick_o,
   output logic [ACC_W-1:0] fsw_o,
   output logic           settled_o,
   output logic [ACC_W:0] est_o
);
   localparam logic [ACC_W-1:0] FSW_LIM = {{(ACC_W-1){1'b0}}, 1'b1} << (ACC_W-2);
   localparam int RUN_W = $clog2(SPAN_MAX + 2);
   localparam int CNT_W = $clog2(SETTLE_K + 1);
   localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(SPAN_MAX + 1);
   localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(SPAN_MAX);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(SETTLE_K);

   logic             move_up, move_dn, moved, rev;
   step_dir_e        dir_now, last_dir;
   logic [ACC_W-1:0] pt_q;
   logic [RUN_W-1:0] run_q;
   logic [CNT_W-1:0] cnt_q;

   if (STEP_DIV == 1) begin : g_tick_every
      assign tick_o = 1'b1;
   end else begin : g_tick_div
      localparam int DIV_W = $clog2(STEP_DIV);
      logic [DIV_W-1:0] div_q;
      assign tick_o = (div_q == DIV_W'(STEP_DIV - 1));
      always_ff @(posedge clk) begin
         if (rst || tick_o) div_q <= '0;
         else               div_q <= div_q + 1'b1;
      end
   end

   assign move_up = tick_o & up_i & (fsw_o < FSW_LIM);
   assign move_dn = tick_o & dn_i & (fsw_o != '0);
   assign moved   = move_up | move_dn;
   assign dir_now = move_up ? DIR_UP : DIR_DN;
   assign rev     = moved & (last_dir != DIR_NONE) & (dir_now != last_dir);

   always_ff @(posedge clk) begin
      if (rst) begin
         fsw_o    <= '0;
         last_dir <= DIR_NONE;
         pt_q     <= '0;
         est_o    <= '0;
         run_q    <= RUN_SAT;
         cnt_q    <= '0;
      end else if (moved) begin
         fsw_o    <= move_up ? fsw_o + 1'b1 : fsw_o - 1'b1;
         last_dir <= dir_now;
         if (rev) begin
            pt_q  <= fsw_o;
            est_o <= {1'b0, fsw_o} + {1'b0, pt_q};
            run_q <= RUN_W'(1);
            if (run_q > RUN_LIM)      cnt_q <= '0;
            else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
         end else begin
            if (run_q != RUN_SAT) run_q <= run_q + 1'b1;
            if (run_q >= RUN_LIM) cnt_q <= '0;
         end
      end
   end

   assign settled_o = (cnt_q == CNT_TOP);

   // R4
   fsw_limit_chk: assert property (@(posedge clk) disable iff (rst)
      fsw_o <= FSW_LIM);
   // R6
   unit_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && fsw_o != $past(fsw_o)) |->
         (fsw_o == $past(fsw_o) + 1'b1 || fsw_o == $past(fsw_o) - 1'b1));
   // R6
   tick_only_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && fsw_o != $past(fsw_o)) |-> $past(tick_o));
   // R7
   settle_on_rev_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(settled_o) |-> $past(rev));
endmodule

// File: rtl/freq_track_meter.sv
module freq_track_meter #(
   parameter int ACC_W       = 10,
   parameter int STEP_DIV    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int SPAN_MAX    = 4,
   parameter int SETTLE_K    = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             meas_in,
   output logic [ACC_W-1:0] fsw_o,
   output logic             dds_sq_o,
   output logic             settled_o,
   output logic [ACC_W:0]   estimate_o
);
   logic step_tick, req_up, req_dn;

   if (ACC_W < 4)    begin : g_bad_acc  $error("ACC_W must be at least 4");    end
   if (STEP_DIV < 1) begin : g_bad_div  $error("STEP_DIV must be at least 1"); end
   if (SPAN_MAX < 1) begin : g_bad_span $error("SPAN_MAX must be at least 1"); end
   if (SETTLE_K < 1) begin : g_bad_k    $error("SETTLE_K must be at least 1"); end

   ftm_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst(rst), .fsw_i(fsw_o), .sq_o(dds_sq_o));

   ftm_edge_order_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk(clk), .rst(rst), .meas_i(meas_in), .dds_i(dds_sq_o),
      .take_i(step_tick), .up_o(req_up), .dn_o(req_dn));

   ftm_tune_counter #(
      .ACC_W(ACC_W), .STEP_DIV(STEP_DIV),
      .SPAN_MAX(SPAN_MAX), .SETTLE_K(SETTLE_K)
   ) u_cnt (
      .clk(clk), .rst(rst), .up_i(req_up), .dn_i(req_dn),
      .tick_o(step_tick), .fsw_o(fsw_o),
      .settled_o(settled_o), .est_o(estimate_o));
endmodule

// File: tb/sim_freq_track_meter.sv
`timescale 1ns/1ps
module sim_freq_track_meter;
   localparam int AW   = 10;
   localparam int STEP = 4;
   localparam int LIM  = 1 << (AW - 2);
   // period in clocks, expected estimate = 2*2^AW/period (half-step units)
   localparam int VEC [4][2] = '{'{24, 85}, '{40, 51}, '{6, 341}, '{10, 204}};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic meas = 1'b0;
   logic [AW-1:0] fsw;
   logic dds_sq, settled;
   logic [AW:0] est;

   int checks = 0, errors = 0, mon_err = 0, mon_chg = 0;
   int half_per = 0, hc = 0;
   int gap = 0;
   logic [AW-1:0] prev_fsw = '0;

   always #2.5 clk = ~clk;

   freq_track_meter #(.ACC_W(AW), .STEP_DIV(STEP)) u0 (
      .clk(clk), .rst(rst), .meas_in(meas), .fsw_o(fsw),
      .dds_sq_o(dds_sq), .settled_o(settled), .estimate_o(est));

   function automatic int iabs(int v);
      return (v < 0) ? -v : v;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // input generator
   always @(negedge clk) begin
      if (half_per == 0) begin
         meas <= 1'b0;
         hc   <= 0;
      end else if (hc + 1 >= half_per) begin
         meas <= ~meas;
         hc   <= 0;
      end else begin
         hc <= hc + 1;
      end
   end

   // R6 monitor: unit steps, no closer than STEP clocks apart
   always @(negedge clk) begin
      if (rst) begin
         gap = STEP;
      end else begin
         gap++;
         if (fsw != prev_fsw) begin
            mon_chg++;
            if (iabs(int'(fsw) - int'(prev_fsw)) != 1 || gap < STEP) begin
               mon_err++;
               $display("FAIL R6: step %0d->%0d after %0d clocks, expected unit step after >= %0d",
                        prev_fsw, fsw, gap, STEP);
            end
            gap = 0;
         end
      end
      prev_fsw = fsw;
   end

   task automatic do_reset();
      @(negedge clk) rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic count_edges(int n, output int dm, output int dd);
      logic pm, pd;
      dm = 0; dd = 0;
      pm = meas; pd = dds_sq;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (meas && !pm) dm++;
         if (dds_sq && !pd) dd++;
         pm = meas; pd = dds_sq;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
   end

   initial begin
      int dm, dd, per, exp2, fsw_lock;
      repeat (4) @(negedge clk);
      // R1 reset state
      check(fsw == '0 && !dds_sq && !settled && est == '0, "R1", int'(fsw) + int'(est), 0);
      rst = 1'b0;

      // R3 constant input: nothing moves
      half_per = 0;
      repeat (1000) @(negedge clk);
      check(fsw == '0, "R3 fsw", int'(fsw), 0);
      check(!settled, "R3 settled", int'(settled), 0);

      foreach (VEC[r]) begin
         per  = VEC[r][0];
         exp2 = VEC[r][1];
         do_reset();
         check(fsw == '0 && !settled && est == '0, "R1 rerun", int'(fsw), 0);
         half_per = per / 2;
         repeat (300) @(negedge clk);
         // R5 input faster than synthesizer: word climbs
         check(fsw > '0, "R5 climb", int'(fsw), 1);
         for (int i = 0; i < 40000 && !settled; i++) @(negedge clk);
         // R7 settles with midpoint estimate
         check(settled, "R7 settled", int'(settled), 1);
         check(iabs(int'(est) - exp2) <= 2, "R7 estimate", int'(est), exp2);
         check(iabs(2 * int'(fsw) - exp2) <= 3, "R5 tracking", 2 * int'(fsw), exp2);
         // R2 synthesized wave matches input in lock
         count_edges(2000, dm, dd);
         check(iabs(dm - dd) <= 2, "R2 edge match", dd, dm);
      end

      // R8 period change after lock drops settled; R5 word falls
      fsw_lock = int'(fsw);
      half_per = 20;
      repeat (500) @(negedge clk);
      check(!settled, "R8 unsettle", int'(settled), 0);
      check(int'(fsw) < fsw_lock - 10, "R5 fall", int'(fsw), fsw_lock - 10);

      // R4 out-of-range input saturates
      do_reset();
      half_per = 1;
      repeat (4000) @(negedge clk);
      check(int'(fsw) == LIM, "R4 saturate", int'(fsw), LIM);
      check(!settled, "R4 not settled", int'(settled), 0);

      // R6 monitor summary
      check(mon_err == 0 && mon_chg > 0, "R6 step rule", mon_err, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule